// File: doc/BRIEF.md
# Serial Port Register Front End with Shared Interrupt

This block is the processor-facing side of a minimal serial port. It decodes a small word-aligned register window in which every register carries only eight meaningful bits. It also holds the storage that sits between the bus and the serial engines: a receive queue of a few characters and a single transmit holding slot. The bit shifters and the baud-rate timer sit outside the block. They hand received characters in, take the character waiting for transmission, and read the 16-bit divisor that software writes as two bytes.

Software sees one status byte. This byte combines live queue flags, two interrupt enables that software can write, and two sticky error flags. Software clears an error flag by writing a 0 into its position, usually with a read-modify-write. A single interrupt output is asserted when either qualified condition is true: the receive enable is set while characters are waiting, or the transmit enable is set while the holding slot is free.

Top module: `uart_regfile`

## Requirements
- R1: After reset the status byte reads 0xA0 (bit 7 transmit slot empty, bit 5 receive queue empty, every other bit 0), `irq` is 0, `tx_char_valid` is 0 and `baud_div` is 0.
- R2: Word index 0..3 (byte offsets 0, 4, 8, 12) read as bytes 0..3 of the `ID_VALUE` parameter, least significant byte first. Writes to them have no effect. Address bits [1:0] are ignored.
- R3: A write to offset 24 sets `baud_div[7:0]` and a write to offset 28 sets `baud_div[15:8]`. Reading either offset returns the stored byte.
- R4: A write to offset 16 loads the transmit slot only while it is empty. It then raises `tx_char_valid` and clears status bit 7. A write while the slot is full is dropped. A `tx_char_taken` pulse empties the slot.
- R5: Status bit 3 reads 1 while the receive queue holds `RX_DEPTH` characters. Status bit 4 reads 1 while it holds exactly `RX_DEPTH`-1. Status bit 5 reads 1 while it is empty.
- R6: A read of offset 16 returns the oldest queued character and removes it. The queue keeps arrival order. A read while the queue is empty returns 0 and removes nothing.
- R7: A character that arrives while the queue is full is discarded and sets status bit 1, the overrun flag. This holds even if a read removes a character in the same cycle.
- R8: A character that arrives with `rx_stop_bad` high sets status bit 0, the framing flag. The character is still queued if there is room.
- R9: Writing offset 20 with bit 0 or bit 1 at 0 clears that flag. Writing a 1 leaves the flag unchanged. Within one cycle, a flag being set by hardware wins over a clearing write.
- R10: Writing offset 20 stores bit 2 (receive enable) and bit 6 (transmit enable). Values written to bits 3, 4, 5 and 7 are ignored.
- R11: `irq` is 1 when the receive enable is set and the queue is not empty.
- R12: `irq` is 1 when the transmit enable is set and the transmit slot is empty. When both enables are 0, `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access (side effects happen at the closing edge) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address and state |
| rx_char_valid | input | 1 | Receive shifter delivers a character this cycle |
| rx_char | input | 8 | Delivered character |
| rx_stop_bad | input | 1 | Stop bit of the delivered character was missing |
| tx_char_valid | output | 1 | Transmit slot holds a character |
| tx_char | output | 8 | Character in the transmit slot |
| tx_char_taken | input | 1 | Transmit shifter has taken the slot contents |
| baud_div | output | 16 | Divisor for the baud timer |
| irq | output | 1 | Combined receive/transmit interrupt |

## Verification
Two updates can reach the overrun flag in the same cycle: hardware setting it, and a software status write clearing it. The bench fills the queue and then, in one cycle, delivers a further character and writes 0x00 to the status register. It judges the result by the status byte read afterwards, where bit 1 must still be 1 and the enables must read 0. The queue contents are then drained to confirm that the extra character was discarded and arrival order was kept.

// File: rtl/uart_regfile_pkg.sv
package uart_regfile_pkg;

   typedef enum logic [2:0] {
      SEL_ID0  = 3'd0,
      SEL_ID1  = 3'd1,
      SEL_ID2  = 3'd2,
      SEL_ID3  = 3'd3,
      SEL_DATA = 3'd4,
      SEL_STAT = 3'd5,
      SEL_DIVL = 3'd6,
      SEL_DIVH = 3'd7
   } reg_sel_e;

   localparam int unsigned ST_FERR    = 0;
   localparam int unsigned ST_OERR    = 1;
   localparam int unsigned ST_RXIE    = 2;
   localparam int unsigned ST_RXFULL  = 3;
   localparam int unsigned ST_RXONE   = 4;
   localparam int unsigned ST_RXEMPTY = 5;
   localparam int unsigned ST_TXIE    = 6;
   localparam int unsigned ST_TXEMPTY = 7;

   localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [CHAR_W-1:0] push_data,
   input  logic              pop,
   output logic [CHAR_W-1:0] head,
   output logic              empty,
   output logic              full,
   output logic              one_left,
   output logic              dropped
);

   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(DEPTH - 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("uart_rx_queue: DEPTH must be at least 2");
      end
   endgenerate

   logic [CHAR_W-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              do_push, do_pop;

   assign full     = (cnt_q == CNT_FULL);
   assign empty    = (cnt_q == '0);
   assign one_left = (cnt_q == CNT_ONE);
   assign do_push  = push && !full;
   assign do_pop   = pop && !empty;
   assign dropped  = push && full;
   assign head     = mem_q[rd_ptr_q];

   function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
      return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (do_push) wr_ptr_q <= next_ptr(wr_ptr_q);
         if (do_pop)  rd_ptr_q <= next_ptr(rd_ptr_q);
         if (do_push && !do_pop)      cnt_q <= cnt_q + CNT_W'(1);
         else if (do_pop && !do_push) cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   generate
      for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mem_q[gi] <= '0;
            else if (do_push && (wr_ptr_q == PTR_W'(gi)))
               mem_q[gi] <= push_data;
         end
      end
   endgenerate

   p_fill_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !full && !pop) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (full && $stable(wr_ptr_q)));

   p_pop_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !empty && !push) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/uart_tx_slot.sv
module uart_tx_slot #(
   parameter int unsigned CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CHAR_W-1:0] load_data,
   input  logic              take,
   output logic              valid,
   output logic [CHAR_W-1:0] data
);

   logic              valid_q;
   logic [CHAR_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         data_q  <= '0;
      end else if (valid_q) begin
         if (take) valid_q <= 1'b0;
      end else if (load) begin
         valid_q <= 1'b1;
         data_q  <= load_data;
      end
   end

   assign valid = valid_q;
   assign data  = data_q;

   p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !take) |=> (valid_q && $stable(data_q)));

endmodule

// File: rtl/uart_stat_irq.sv
module uart_stat_irq
   import uart_regfile_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stat_wr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              frame_set,
   input  logic              ovr_set,
   input  logic              rx_empty,
   input  logic              rx_full,
   input  logic              rx_one,
   input  logic              tx_empty,
   output logic [BYTE_W-1:0] status,
   output logic              irq
);

   logic ferr_q, oerr_q, rxie_q, txie_q;
   logic ferr_keep, oerr_keep;
   logic irq_cond;

   assign ferr_keep = !stat_wr || wdata[ST_FERR];
   assign oerr_keep = !stat_wr || wdata[ST_OERR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ferr_q <= 1'b0;
         oerr_q <= 1'b0;
         rxie_q <= 1'b0;
         txie_q <= 1'b0;
      end else begin
         ferr_q <= frame_set || (ferr_q && ferr_keep);
         oerr_q <= ovr_set   || (oerr_q && oerr_keep);
         if (stat_wr) begin
            rxie_q <= wdata[ST_RXIE];
            txie_q <= wdata[ST_TXIE];
         end
      end
   end

   always_comb begin
      status             = '0;
      status[ST_FERR]    = ferr_q;
      status[ST_OERR]    = oerr_q;
      status[ST_RXIE]    = rxie_q;
      status[ST_RXFULL]  = rx_full;
      status[ST_RXONE]   = rx_one;
      status[ST_RXEMPTY] = rx_empty;
      status[ST_TXIE]    = txie_q;
      status[ST_TXEMPTY] = tx_empty;
   end

   assign irq_cond = (rxie_q && !rx_empty) || (txie_q && tx_empty);

   generate
      if (IRQ_REG) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_cond;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_cond;
         p_irq_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (!status[ST_RXIE] && !status[ST_TXIE]) |-> !irq);
      end
   endgenerate

   p_err_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_set || ovr_set) |=> (status[ST_FERR] || status[ST_OERR]));

   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (status[ST_OERR] && !stat_wr) |=> status[ST_OERR]);

endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
   import uart_regfile_pkg::*;
#(
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned RX_DEPTH = 4,
   parameter logic [31:0] ID_VALUE = 32'h5A31_C007,
   parameter bit          IRQ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              rx_char_valid,
   input  logic [7:0]        rx_char,
   input  logic              rx_stop_bad,
   output logic              tx_char_valid,
   output logic [7:0]        tx_char,
   input  logic              tx_char_taken,
   output logic [15:0]       baud_div,
   output logic              irq
);

   localparam int unsigned SEL_LO = 2;
   localparam int unsigned SEL_HI = 4;

   generate
      if (ADDR_W < SEL_HI + 1) begin : g_bad_addr
         $error("uart_regfile: ADDR_W must be at least 5");
      end
   endgenerate

   reg_sel_e          sel;
   logic              hit;
   logic [BYTE_W-1:0] div_lo_q, div_hi_q;
   logic [BYTE_W-1:0] rx_head, status;
   logic              rx_empty, rx_full, rx_one, rx_drop;
   logic              pop_rx, load_tx, stat_wr;

   assign sel = reg_sel_e'(bus_addr[SEL_HI:SEL_LO]);

   generate
      if (ADDR_W > SEL_HI + 1) begin : g_upper_decode
         assign hit = (bus_addr[ADDR_W-1:SEL_HI+1] == '0);
      end else begin : g_exact_decode
         assign hit = 1'b1;
      end
   endgenerate

   assign pop_rx  = bus_rd && hit && (sel == SEL_DATA) && !rx_empty;
   assign load_tx = bus_wr && hit && (sel == SEL_DATA);
   assign stat_wr = bus_wr && hit && (sel == SEL_STAT);

   uart_rx_queue #(
      .DEPTH  (RX_DEPTH),
      .CHAR_W (BYTE_W)
   ) u_rxq (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (rx_char_valid),
      .push_data (rx_char),
      .pop       (pop_rx),
      .head      (rx_head),
      .empty     (rx_empty),
      .full      (rx_full),
      .one_left  (rx_one),
      .dropped   (rx_drop)
   );

   uart_tx_slot #(
      .CHAR_W (BYTE_W)
   ) u_txs (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_tx),
      .load_data (bus_wdata),
      .take      (tx_char_taken),
      .valid     (tx_char_valid),
      .data      (tx_char)
   );

   uart_stat_irq #(
      .IRQ_REG (IRQ_REG)
   ) u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .stat_wr   (stat_wr),
      .wdata     (bus_wdata),
      .frame_set (rx_char_valid && rx_stop_bad),
      .ovr_set   (rx_drop),
      .rx_empty  (rx_empty),
      .rx_full   (rx_full),
      .rx_one    (rx_one),
      .tx_empty  (!tx_char_valid),
      .status    (status),
      .irq       (irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_lo_q <= '0;
         div_hi_q <= '0;
      end else if (bus_wr && hit) begin
         if (sel == SEL_DIVL) div_lo_q <= bus_wdata;
         if (sel == SEL_DIVH) div_hi_q <= bus_wdata;
      end
   end

   assign baud_div = {div_hi_q, div_lo_q};

   always_comb begin
      bus_rdata = '0;
      if (hit) begin
         unique case (sel)
            SEL_ID0:  bus_rdata = ID_VALUE[7:0];
            SEL_ID1:  bus_rdata = ID_VALUE[15:8];
            SEL_ID2:  bus_rdata = ID_VALUE[23:16];
            SEL_ID3:  bus_rdata = ID_VALUE[31:24];
            SEL_DATA: bus_rdata = rx_empty ? '0 : rx_head;
            SEL_STAT: bus_rdata = status;
            SEL_DIVL: bus_rdata = div_lo_q;
            SEL_DIVH: bus_rdata = div_hi_q;
            default:  bus_rdata = '0;
         endcase
      end
   end

   p_divisor_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(baud_div));

   p_tx_ignore_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_char_valid && !tx_char_taken) |=> $stable(tx_char));

endmodule

// File: tb/uart_regfile_tb_top.sv
`timescale 1ns/1ps
module uart_regfile_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] bus_addr = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       rx_char_valid = 1'b0, rx_stop_bad = 1'b0;
   logic [7:0] rx_char = '0;
   logic       tx_char_valid, tx_char_taken = 1'b0;
   logic [7:0] tx_char;
   logic [15:0] baud_div;
   logic       irq;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   uart_regfile dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_char_valid(rx_char_valid), .rx_char(rx_char), .rx_stop_bad(rx_stop_bad),
      .tx_char_valid(tx_char_valid), .tx_char(tx_char), .tx_char_taken(tx_char_taken),
      .baud_div(baud_div), .irq(irq)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic rx_in(input logic [7:0] ch, input logic bad);
      @(negedge clk);
      rx_char = ch; rx_stop_bad = bad; rx_char_valid = 1'b1;
      @(negedge clk);
      rx_char_valid = 1'b0; rx_stop_bad = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(5'd20, v);
      check("R1 status after reset", v, 8'hA0);
      check("R1 irq after reset", irq, 1'b0);
      check("R1 tx valid after reset", tx_char_valid, 1'b0);
      check("R1 divisor after reset", baud_div, 16'h0000);
   endtask

   task automatic t_ident();
      logic [7:0] v;
      rd(5'd0, v);  check("R2 id byte 0", v, 8'h07);
      rd(5'd4, v);  check("R2 id byte 1", v, 8'hC0);
      rd(5'd9, v);  check("R2 id byte 2 low addr bits ignored", v, 8'h31);
      rd(5'd12, v); check("R2 id byte 3", v, 8'h5A);
      wr(5'd0, 8'hFF);
      rd(5'd0, v);  check("R2 id write ignored", v, 8'h07);
   endtask

   task automatic t_divisor();
      logic [7:0] v;
      wr(5'd24, 8'h34);
      wr(5'd28, 8'h12);
      check("R3 divisor value", baud_div, 16'h1234);
      rd(5'd28, v); check("R3 divisor high readback", v, 8'h12);
   endtask

   task automatic t_tx();
      logic [7:0] v;
      wr(5'd16, 8'h3C);
      check("R4 tx valid after load", tx_char_valid, 1'b1);
      check("R4 tx char", tx_char, 8'h3C);
      rd(5'd20, v); check("R4 status slot full", v, 8'h20);
      wr(5'd16, 8'h99);
      check("R4 write while full dropped", tx_char, 8'h3C);
      @(negedge clk); tx_char_taken = 1'b1;
      @(negedge clk); tx_char_taken = 1'b0;
      check("R4 slot empty after take", tx_char_valid, 1'b0);
   endtask

   task automatic t_rx_order();
      logic [7:0] v;
      rx_in(8'hA1, 1'b0); rx_in(8'hA2, 1'b0); rx_in(8'hA3, 1'b0);
      rd(5'd20, v); check("R5 one slot left flag", v, 8'h90);
      rx_in(8'hA4, 1'b0);
      rd(5'd20, v); check("R5 full flag", v, 8'h88);
      rx_in(8'hEE, 1'b0);
      rd(5'd20, v); check("R7 overrun set", v, 8'h8A);
      for (int i = 0; i < 4; i++) begin
         rd(5'd16, v);
         check("R6 arrival order", v, 8'hA1 + 8'(i));
      end
      rd(5'd16, v); check("R6 empty read returns 0", v, 8'h00);
      rd(5'd20, v); check("R6 empty read no pop, R7 sticky", v, 8'hA2);
      wr(5'd20, 8'h00);
      rd(5'd20, v); check("R9 overrun cleared by 0", v, 8'hA0);
   endtask

   task automatic t_frame();
      logic [7:0] v;
      rx_in(8'h55, 1'b1);
      rd(5'd20, v); check("R8 framing set, char queued", v, 8'h81);
      wr(5'd20, 8'h01);
      rd(5'd20, v); check("R9 writing 1 keeps flag", v, 8'h81);
      wr(5'd20, 8'h00);
      rd(5'd20, v); check("R9 writing 0 clears flag", v, 8'h80);
      rd(5'd16, v); check("R8 bad-stop char data", v, 8'h55);
   endtask

   task automatic t_ro_bits();
      logic [7:0] v;
      wr(5'd20, 8'hFF);
      rd(5'd20, v); check("R10 live bits ignore write", v, 8'hE4);
      check("R12 tx irq with slot empty", irq, 1'b1);
      wr(5'd20, 8'h00);
      check("R12 irq quiet with enables off", irq, 1'b0);
   endtask

   task automatic t_irq();
      logic [7:0] v;
      wr(5'd20, 8'h04);
      check("R11 rx irq idle when empty", irq, 1'b0);
      rx_in(8'h77, 1'b0);
      check("R11 rx irq on data", irq, 1'b1);
      rd(5'd16, v);
      check("R11 rx irq drops after pop", irq, 1'b0);
      wr(5'd20, 8'h40);
      check("R12 tx irq", irq, 1'b1);
      wr(5'd16, 8'h12);
      check("R12 tx irq off while full", irq, 1'b0);
      @(negedge clk); tx_char_taken = 1'b1;
      @(negedge clk); tx_char_taken = 1'b0;
      check("R12 tx irq after take", irq, 1'b1);
      wr(5'd20, 8'h00);
   endtask

   task automatic t_collide();
      logic [7:0] v;
      for (int i = 0; i < 4; i++) rx_in(8'hC0 + 8'(i), 1'b0);
      @(negedge clk);
      rx_char = 8'hDD; rx_char_valid = 1'b1;
      bus_addr = 5'd20; bus_wdata = 8'h00; bus_wr = 1'b1;
      @(negedge clk);
      rx_char_valid = 1'b0; bus_wr = 1'b0;
      rd(5'd20, v); check("R9 hardware set beats clearing write", v, 8'h8A);
      for (int i = 0; i < 4; i++) begin
         rd(5'd16, v);
         check("R7 dropped char absent", v, 8'hC0 + 8'(i));
      end
      wr(5'd20, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ident();
      t_divisor();
      t_tx();
      t_rx_order();
      t_frame();
      t_ro_bits();
      t_irq();
      t_collide();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

endmodule